// File: doc/BRIEF.md
# Brute-Force Key Search Controller

This block runs an exhaustive key search against a fixed-latency decryption pipeline without any per-key work from the host. The host programs four values: a first key, a last key, one known ciphertext block and the plaintext it expects that block to decrypt to. It then writes a start command. From the next cycle on, the controller sends one candidate key into the pipeline every clock, beginning exactly at the first key and counting up by one. The range may wrap past the all-ones key back to zero. A record of each candidate key and whether it is live travels beside the pipeline, so every result leaving the pipeline is paired with the key that produced it.

When a result equals the expected plaintext, the controller stops. It discards everything still in flight, keeps the matching key and raises a local flag. That flag is ORed with an upstream interrupt input, which lets many engines share one interrupt line, each passing its request down a chain. If the last key is compared without a match, the controller stops and reports that the range is exhausted. The host polls a small register interface, roughly once per second, to read the state, the winning key and the number of keys compared. It then acknowledges the result.

Top module: `keysearch_ctrl`

## Requirements
- R1: After reset the status state code reads 0 (idle), the keys-compared count reads 0, `dp_issue` is low and `irq_out` equals `irq_in`.
- R2: A write to address 0 with bit 0 set (start), accepted when the state is not running (1), makes the state running. `dp_issue` rises in the next cycle with `dp_key` equal to the first key (address 1). While running it presents that key plus one in each following cycle.
- R3: When a result `dp_result` that arrives LAT cycles after its key was issued equals the target (address 4), the state becomes found (2). The key that produced that result is held at address 5 and no further keys are issued.
- R4: On a match, results of keys issued after the matching key are discarded. If several keys in the range match, the first one issued is reported, and neither the reported key nor the count changes afterwards.
- R5: If the result for the last key (address 2) is compared without a match, the state becomes exhausted (3) and the local interrupt flag stays clear.
- R6: When the last key is numerically below the first key, the search wraps from the all-ones key to zero and ends at the last key.
- R7: Address 6 reads the number of results compared since the last start, including the matching one. It is cleared by a start.
- R8: `irq_out` is the OR of `irq_in` and a local flag. The local flag is set by a match, is readable at status bit 2, and is cleared only by a write to address 0 with bit 1 set (acknowledge).
- R9: While running, writes to addresses 1 to 4 are ignored: read-back returns the values held before the write.
- R10: An acknowledge in the found or exhausted state returns the state to idle (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Host read data for `reg_addr` (combinational) |
| dp_issue | output | 1 | A candidate key is offered to the pipeline this cycle |
| dp_key | output | KEY_W | Candidate key sent to the pipeline |
| dp_block | output | BLK_W | Known ciphertext sent to the pipeline |
| dp_result | input | BLK_W | Pipeline output, LAT cycles after issue |
| irq_in | input | 1 | Interrupt from the upstream engine in the chain |
| irq_out | output | 1 | Chained interrupt to the downstream engine |

## Verification
Several properties are checked by assertions on every cycle. Issued keys step by exactly one while running. The key-tracking line is empty one cycle after a flush. Configuration registers stay still while running. A found result and its key hold until the host acts. The count never advances by more than one per cycle. The chained output always follows a raised upstream request. The bench scenarios are needed for behaviour that spans a whole search: that the reported key is the one that actually produced the match, that the first of several matching keys wins, that a range wraps and ends correctly, and that exhaustion and the final counts match the range size.

// File: rtl/keysearch_pkg.sv
package keysearch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FOUND = 2'd2,
    ST_EXH   = 2'd3
  } srch_state_e;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_FIRST  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_LAST   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_CIPHER = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_TARGET = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_HITKEY = 3'd5;
  localparam logic [REG_ADDR_W-1:0] A_TRIED  = 3'd6;

  localparam int unsigned CTRL_GO_BIT  = 0;
  localparam int unsigned CTRL_ACK_BIT = 1;
  localparam int unsigned STAT_IRQ_BIT = 2;

endpackage

// File: rtl/ks_regs.sv
module ks_regs
  import keysearch_pkg::*;
#(
  parameter int unsigned KEY_W  = 24,
  parameter int unsigned BLK_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  running,
  input  srch_state_e           state,
  input  logic                  irq_local,
  input  logic [KEY_W-1:0]      hit_key,
  input  logic [CNT_W-1:0]      tried,
  output logic [KEY_W-1:0]      first_key,
  output logic [KEY_W-1:0]      last_key,
  output logic [BLK_W-1:0]      cipher,
  output logic [BLK_W-1:0]      target,
  output logic                  go,
  output logic                  ack,
  output logic [DATA_W-1:0]     rdata
);

  logic cfg_we;
  logic first_en, last_en, cipher_en, target_en;
  logic [KEY_W-1:0] first_q, last_q;
  logic [BLK_W-1:0] cipher_q, target_q;

  // Configuration is frozen while a search is running.
  always_comb begin
    cfg_we    = we && !running;
    first_en  = cfg_we && (addr == A_FIRST);
    last_en   = cfg_we && (addr == A_LAST);
    cipher_en = cfg_we && (addr == A_CIPHER);
    target_en = cfg_we && (addr == A_TARGET);
    go        = we && (addr == A_CTRL) && wdata[CTRL_GO_BIT];
    ack       = we && (addr == A_CTRL) && wdata[CTRL_ACK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      last_q   <= '0;
      cipher_q <= '0;
      target_q <= '0;
    end else begin
      if (first_en)  first_q  <= wdata[KEY_W-1:0];
      if (last_en)   last_q   <= wdata[KEY_W-1:0];
      if (cipher_en) cipher_q <= wdata[BLK_W-1:0];
      if (target_en) target_q <= wdata[BLK_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[1:0]          = state;
        rdata[STAT_IRQ_BIT] = irq_local;
      end
      A_FIRST:  rdata[KEY_W-1:0] = first_q;
      A_LAST:   rdata[KEY_W-1:0] = last_q;
      A_CIPHER: rdata[BLK_W-1:0] = cipher_q;
      A_TARGET: rdata[BLK_W-1:0] = target_q;
      A_HITKEY: rdata[KEY_W-1:0] = hit_key;
      A_TRIED:  rdata[CNT_W-1:0] = tried;
      default:  rdata = '0;
    endcase
  end

  assign first_key = first_q;
  assign last_key  = last_q;
  assign cipher    = cipher_q;
  assign target    = target_q;

  // R9: nothing in the configuration moves across a cycle that began running
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(first_q) && $stable(last_q) &&
                 $stable(cipher_q) && $stable(target_q)));

endmodule

// File: rtl/ks_keyline.sv
module ks_keyline #(
  parameter int unsigned LAT   = 8,
  parameter int unsigned KEY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  output logic             tail_valid,
  output logic [KEY_W-1:0] tail_key
);

  logic             vld_q [LAT];
  logic [KEY_W-1:0] key_q [LAT];
  logic             vld_d [LAT];
  logic             key_en [LAT];
  logic [KEY_W-1:0] key_d [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        vld_d[i]  = in_valid && !flush;
        key_en[i] = in_valid;
        key_d[i]  = in_key;
      end
    end else begin : g_body
      always_comb begin
        vld_d[i]  = vld_q[i-1] && !flush;
        key_en[i] = vld_q[i-1];
        key_d[i]  = key_q[i-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        key_q[i] <= '0;
      end else begin
        vld_q[i] <= vld_d[i];
        if (key_en[i]) key_q[i] <= key_d[i];
      end
    end
  end

  assign tail_valid = vld_q[LAT-1];
  assign tail_key   = key_q[LAT-1];

  // R4: after a flush nothing that was in flight reaches the comparator
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tail_valid);

endmodule

// File: rtl/ks_seq.sv
module ks_seq
  import keysearch_pkg::*;
#(
  parameter int unsigned KEY_W = 24,
  parameter int unsigned BLK_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             ack,
  input  logic [KEY_W-1:0] first_key,
  input  logic [KEY_W-1:0] last_key,
  input  logic [BLK_W-1:0] target,
  input  logic             tail_valid,
  input  logic [KEY_W-1:0] tail_key,
  input  logic [BLK_W-1:0] result,
  output srch_state_e      state,
  output logic             issue,
  output logic [KEY_W-1:0] cur_key,
  output logic             line_valid,
  output logic             hit,
  output logic [KEY_W-1:0] hit_key,
  output logic [CNT_W-1:0] tried,
  output logic             irq_flag
);

  localparam logic [KEY_W-1:0] KEY_ONE = KEY_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  srch_state_e      state_q, state_d;
  logic [KEY_W-1:0] cur_q, cur_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] hit_q, hit_d;
  logic             irq_q, irq_d;
  logic             running;

  always_comb begin
    running    = (state_q == ST_RUN);
    issue      = running && !done_q;
    hit        = running && tail_valid && (result == target);
    line_valid = issue && !hit;
  end

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    hit_d   = hit_q;
    irq_d   = irq_q;

    if (ack) irq_d = 1'b0;

    if (go && !running) begin
      state_d = ST_RUN;
      cur_d   = first_key;
      done_d  = 1'b0;
      cnt_d   = '0;
    end else if (running) begin
      if (tail_valid) begin
        cnt_d = cnt_q + CNT_ONE;
        if (hit) begin
          state_d = ST_FOUND;
          hit_d   = tail_key;
          irq_d   = 1'b1;
        end else if (tail_key == last_key) begin
          state_d = ST_EXH;
        end
      end
      if (line_valid) begin
        cur_d = cur_q + KEY_ONE;
        if (cur_q == last_key) done_d = 1'b1;
      end
    end else if (ack) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      hit_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      hit_q   <= hit_d;
      irq_q   <= irq_d;
    end
  end

  assign state    = state_q;
  assign cur_key  = cur_q;
  assign hit_key  = hit_q;
  assign tried    = cnt_q;
  assign irq_flag = irq_q;

  // R2: consecutive issued keys step by exactly one
  assert_key_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && running) |=> (!issue || cur_q == $past(cur_q) + KEY_ONE));

  // R3: a found result and its key hold until the host acts
  assert_found_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FOUND && !go && !ack) |=> (state_q == ST_FOUND && $stable(hit_q)));

  // R7: the count advances by at most one per cycle while running
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));

  // R5: exhaustion never raises the local interrupt flag
  assert_exh_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !irq_q) |=> (state_q != ST_EXH || !irq_q));

endmodule

// File: rtl/keysearch_ctrl.sv
module keysearch_ctrl
  import keysearch_pkg::*;
#(
  parameter int unsigned KEY_W  = 24,
  parameter int unsigned BLK_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LAT    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  dp_issue,
  output logic [KEY_W-1:0]      dp_key,
  output logic [BLK_W-1:0]      dp_block,
  input  logic [BLK_W-1:0]      dp_result,
  input  logic                  irq_in,
  output logic                  irq_out
);

  srch_state_e      state;
  logic             go, ack, issue, line_valid, hit, irq_flag;
  logic             tail_valid;
  logic [KEY_W-1:0] first_key, last_key, cur_key, hit_key, tail_key;
  logic [BLK_W-1:0] cipher, target;
  logic [CNT_W-1:0] tried;

  ks_regs #(
    .KEY_W(KEY_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .running(state == ST_RUN), .state(state), .irq_local(irq_flag),
    .hit_key(hit_key), .tried(tried),
    .first_key(first_key), .last_key(last_key), .cipher(cipher), .target(target),
    .go(go), .ack(ack), .rdata(reg_rdata)
  );

  ks_seq #(
    .KEY_W(KEY_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .ack(ack),
    .first_key(first_key), .last_key(last_key), .target(target),
    .tail_valid(tail_valid), .tail_key(tail_key), .result(dp_result),
    .state(state), .issue(issue), .cur_key(cur_key), .line_valid(line_valid),
    .hit(hit), .hit_key(hit_key), .tried(tried), .irq_flag(irq_flag)
  );

  ks_keyline #(
    .LAT(LAT), .KEY_W(KEY_W)
  ) line_i (
    .clk(clk), .rst_n(rst_n), .flush(hit), .in_valid(line_valid), .in_key(cur_key),
    .tail_valid(tail_valid), .tail_key(tail_key)
  );

  assign dp_issue = issue;
  assign dp_key   = cur_key;
  assign dp_block = cipher;
  assign irq_out  = irq_flag | irq_in;

  // R8: an upstream request always passes down the chain
  assert_chain_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |-> irq_out);

endmodule

// File: tb/keysearch_ctrl_tb_top.sv
`timescale 1ns/100ps
module keysearch_ctrl_tb_top;

  localparam int KW  = 24;
  localparam int BW  = 32;
  localparam int DW  = 32;
  localparam int LAT = 8;
  localparam logic [BW-1:0] CT = 32'hA5C3_0F96;

  logic          clk, rst_n, reg_we, irq_in, irq_out, dp_issue;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [KW-1:0] dp_key;
  logic [BW-1:0] dp_block, dp_result;
  logic          fmode;
  logic [BW-1:0] pipe_q [LAT];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  keysearch_ctrl #(.KEY_W(KW), .BLK_W(BW), .DATA_W(DW), .CNT_W(32), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_issue(dp_issue),
    .dp_key(dp_key), .dp_block(dp_block), .dp_result(dp_result),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Stand-in transform: mode 0 is injective, mode 1 ignores the two low key bits.
  function automatic logic [BW-1:0] xf(input logic [KW-1:0] k, input logic m);
    if (m) return {k[7:2], 2'b00, k[23:2], 2'b00};
    return {k[7:0], k};
  endfunction

  always_ff @(posedge clk) begin
    pipe_q[0] <= dp_block ^ xf(dp_key, fmode);
    for (int i = 1; i < LAT; i++) pipe_q[i] <= pipe_q[i-1];
  end
  assign dp_result = pipe_q[LAT-1];

  typedef struct packed {
    logic [23:0] s;
    logic [23:0] e;
    logic [23:0] m;
    logic [1:0]  st;
    logic [31:0] cnt;
    logic [23:0] fk;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{24'd100,     24'd200,     24'd150,  2'd2, 32'd51,  24'd150},
    '{24'd16,      24'd31,      24'd64,   2'd3, 32'd16,  24'd0},
    '{24'hFFFFFE,  24'h000003,  24'h1,    2'd2, 32'd4,   24'h1},
    '{24'hFFFFFC,  24'h000001,  24'h10,   2'd3, 32'd6,   24'd0},
    '{24'd5,       24'd9,       24'd5,    2'd2, 32'd1,   24'd5},
    '{24'd5,       24'd9,       24'd9,    2'd2, 32'd5,   24'd9},
    '{24'd7,       24'd7,       24'd8,    2'd3, 32'd1,   24'd0},
    '{24'd0,       24'd999,     24'd998,  2'd2, 32'd999, 24'd998}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(3'd0, s);
      n++;
    end while (s[1:0] == 2'd1 && n < 20000);
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] e, input logic [23:0] m);
    wr(3'd1, 32'(s));
    wr(3'd2, 32'(e));
    wr(3'd3, CT);
    wr(3'd4, CT ^ xf(m, fmode));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_in = 1'b0; fmode = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    rd(3'd0, r); chk("R1 status", r, 32'd0);
    rd(3'd6, r); chk("R1 count", r, 32'd0);
    chk("R1 dp_issue", 32'(dp_issue), 32'd0);
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    irq_in = 1'b1; #0.5;
    chk("R8 chain pass idle", 32'(irq_out), 32'd1);
    irq_in = 1'b0; #0.5;
    chk("R8 chain low idle", 32'(irq_out), 32'd0);

    // Table walk: R3 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      fmode = 1'b0;
      setup(VECS[i].s, VECS[i].e, VECS[i].m);
      wr(3'd0, 32'h1);
      wait_done();
      rd(3'd0, r); chk($sformatf("R3/R5 state vec%0d", i), 32'(r[1:0]), 32'(VECS[i].st));
      rd(3'd6, r); chk($sformatf("R7 count vec%0d", i), r, VECS[i].cnt);
      if (VECS[i].st == 2'd2) begin
        rd(3'd5, r); chk($sformatf("R3 key vec%0d", i), r, 32'(VECS[i].fk));
        chk($sformatf("R8 irq found vec%0d", i), 32'(irq_out), 32'd1);
      end else begin
        chk($sformatf("R5 irq clear vec%0d", i), 32'(irq_out), 32'd0);
      end
      wr(3'd0, 32'h2);
      @(negedge clk);
      rd(3'd0, r); chk($sformatf("R10 idle after ack vec%0d", i), r, 32'd0);
      chk($sformatf("R8 irq after ack vec%0d", i), 32'(irq_out), 32'd0);
    end

    // R2: issue sequence, R9: frozen configuration
    fmode = 1'b0;
    setup(24'h300, 24'h3FF, 24'h10);
    wr(3'd0, 32'h1);
    chk("R2 issue first", 32'(dp_issue), 32'd1);
    chk("R2 key first", 32'(dp_key), 32'h300);
    @(negedge clk);
    chk("R2 key +1", 32'(dp_key), 32'h301);
    @(negedge clk);
    chk("R2 key +2", 32'(dp_key), 32'h302);
    wr(3'd1, 32'h555);
    wr(3'd4, 32'h0);
    rd(3'd1, r); chk("R9 first key held", r, 32'h300);
    rd(3'd4, r); chk("R9 target held", r, CT ^ xf(24'h10, 1'b0));
    wait_done();
    rd(3'd0, r); chk("R5 exhausted", 32'(r[1:0]), 32'd3);
    rd(3'd6, r); chk("R7 full range count", r, 32'd256);
    chk("R2 issue stops", 32'(dp_issue), 32'd0);
    wr(3'd0, 32'h2);

    // R4: several matching keys, first issued wins, in-flight results discarded
    fmode = 1'b1;
    setup(24'h21, 24'h40, 24'h24);
    wr(3'd0, 32'h1);
    wait_done();
    rd(3'd0, r); chk("R4 found", 32'(r[1:0]), 32'd2);
    rd(3'd5, r); chk("R4 first match key", r, 32'h24);
    repeat (12) @(negedge clk);
    rd(3'd5, r); chk("R4 key unchanged later", r, 32'h24);
    rd(3'd6, r); chk("R4 count unchanged later", r, 32'd4);
    chk("R3 issue stopped", 32'(dp_issue), 32'd0);

    // R8: local flag only cleared by ack; start does not clear it
    wr(3'd0, 32'h1);
    #0.5;
    chk("R8 flag survives start", 32'(irq_out), 32'd1);
    wait_done();
    rd(3'd0, r); chk("R8 status irq bit", 32'(r[2]), 32'd1);
    wr(3'd0, 32'h2);
    #0.5;
    chk("R8 ack clears", 32'(irq_out), 32'd0);

    finished = 1;
    summary();
    $finish;
  end

endmodule